// File: doc/BRIEF.md
# Local Memory Region Decoder

This block sits beside the processor core's local bus and decides, for every access, whether one of two tightly coupled memories answers: a general SRAM, or a fixed 4096 x 32 lookup-table memory. Each memory has its own region register holding a 16-Kbyte-aligned base (address bits 31:14) and a control byte. A hit needs a valid region, a matching upper address, and an access type that the control byte does not mask. Masking drops the memory's chip enable, so a memory that holds only operands, or only code, stays off for the other kind of cycle and saves power.

Instruction fetches go to the local memories and the instruction cache in parallel. When a fetch lands in a local memory, the block raises a cancel line so that the cache result is thrown away. The read completes in one cycle: the enable is raised in the request cycle, and in the following cycle the 32-bit word is returned, with the requested byte or half-word right-justified. If both regions decode the same address, the SRAM wins.

A small state machine tracks the data phase. In `ST_IDLE`, transition `T_WAIT` keeps the machine idle when no memory is enabled, and `T_ACCEPT` moves it to `ST_DATA` on an enabled access. In `ST_DATA` the response is presented. From there, `T_CHAIN` stays in `ST_DATA` when a new access is enabled in the same cycle, and `T_DRAIN` returns to `ST_IDLE` otherwise.

Top module: `lmd_local_mem_decoder`

## Requirements
- R1: While reset is held and right after it, both region registers read as invalid with base 0, no chip enable or cancel is raised, and `rd_valid` is 0.
- R2: An access hits a memory when `req_valid` is 1, that region's valid bit (control bit 0) is 1, `req_addr[31:14]` equals the region base, and the access type is not masked. A hit raises that memory's chip enable in the same cycle; a miss leaves it low.
- R3: A region whose valid bit is 0 never hits, even when the address matches its base.
- R4: The control byte masks are: bit1 user data, bit2 user fetch, bit3 supervisor data, bit4 supervisor fetch. `req_fetch`=1 marks a fetch and `req_super`=1 marks supervisor mode. When the mask gate (bit5) is 1, a masked access type is a miss: no enable and no cancel. For example, 0x35 serves data only and 0x2B serves fetches only.
- R5: When bit5 is 0, bits 1 to 4 have no effect, and every access type can hit.
- R6: When both regions hit the same address, only `sram_ce` rises and `rom_ce` stays low.
- R7: `icache_cancel` is 1 exactly when `req_fetch` is 1 and one of the memory enables is 1 in the same cycle.
- R8: One cycle after an enabled access, `rd_valid` is 1 for exactly that cycle, carrying `sram_rdata` for an SRAM hit or the table word for a table hit.
- R9: Table word i (word index = `req_addr[13:2]`) holds {4'hA, i, 4'h5, i}. The core has no way to write it.
- R10: `req_size` 00 returns a byte, 01 a half-word, and 10 or 11 the full word. Lanes are big-endian: byte lane 0 is bits 31:24, and half-word 0 is bits 31:16. The selected part is zero-extended into `rd_data`.
- R11: A register write (`cfg_we`=1; `cfg_sel` 0 for the SRAM region, 1 for the table region) stores `cfg_wdata[31:14]` as the base and `cfg_wdata[5:0]` as the control. It is used from the next cycle on.
- R12: `sram_addr` carries the word index `req_addr[13:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_sel | input | 1 | Region select: 0 SRAM, 1 table memory |
| cfg_wdata | input | 32 | Base in [31:14], control in [5:0] |
| req_valid | input | 1 | Access request |
| req_addr | input | 32 | Byte address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_size | input | 2 | 00 byte, 01 half-word, 1x word |
| sram_rdata | input | 32 | SRAM word, valid in the cycle after `sram_ce` |
| sram_ce | output | 1 | SRAM chip enable |
| sram_addr | output | 12 | SRAM word index |
| rom_ce | output | 1 | Table memory enable |
| icache_cancel | output | 1 | Discard the parallel cache lookup |
| rd_valid | output | 1 | Read data phase |
| rd_data | output | 32 | Lane-aligned read data |

## Verification
The assertions assume that `sram_rdata` is driven by an SRAM with one cycle of latency, and that `req_addr` holds its value while `req_valid` is 1 through the edge that samples it. The table-content check also relies on the response cycle immediately following the table enable. The bench meets these assumptions by changing requests and register writes only on the falling edge, and by keeping `sram_rdata` at a constant known word. Every request is followed by an idle cycle in which the response is checked.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    // control byte of a region register, bit5 down to bit0
    typedef struct packed {
        logic gate;     // bit5: mask bits take effect
        logic sf_off;   // bit4: supervisor fetch masked
        logic sd_off;   // bit3: supervisor data masked
        logic uf_off;   // bit2: user fetch masked
        logic ud_off;   // bit1: user data masked
        logic valid;    // bit0: region enabled
    } region_ctl_t;

    typedef enum logic {SRC_SRAM, SRC_TABLE} src_e;

    typedef enum logic {ST_IDLE, ST_DATA} phase_e;

    function automatic logic [DATA_W-1:0] table_word(input logic [15:0] idx);
        return {4'hA, idx[11:0], 4'h5, idx[11:0]};
    endfunction

endpackage

// File: rtl/lmd_region_match.sv
module lmd_region_match
    import lmd_pkg::*;
#(
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_base,
    input  region_ctl_t      wr_ctl,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             acc_fetch,
    input  logic             acc_super,
    output logic             match
);

    logic [TAG_W-1:0] base_q;
    region_ctl_t      ctl_q;
    logic             type_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ctl_q  <= '0;
        end else if (wr_en) begin
            base_q <= wr_base;
            ctl_q  <= wr_ctl;
        end
    end

    always_comb begin
        unique case ({acc_super, acc_fetch})
            2'b00: type_off = ctl_q.ud_off;
            2'b01: type_off = ctl_q.uf_off;
            2'b10: type_off = ctl_q.sd_off;
            2'b11: type_off = ctl_q.sf_off;
        endcase
    end

    assign match = ctl_q.valid && (acc_tag == base_q) && !(ctl_q.gate && type_off);

endmodule

// File: rtl/lmd_table_rom.sv
module lmd_table_rom
    import lmd_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= table_word(16'(idx));
    end

endmodule

// File: rtl/lmd_lane_align.sv
module lmd_lane_align
    import lmd_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        lane,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] data
);

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                unique case (lane)
                    2'd0: data = {24'b0, word[31:24]};
                    2'd1: data = {24'b0, word[23:16]};
                    2'd2: data = {24'b0, word[15:8]};
                    2'd3: data = {24'b0, word[7:0]};
                endcase
            end
            SZ_HALF:              data = lane[1] ? {16'b0, word[15:0]} : {16'b0, word[31:16]};
            SZ_WORD, SZ_WORD_ALT: data = word;
        endcase
    end

endmodule

// File: rtl/lmd_local_mem_decoder.sv
module lmd_local_mem_decoder
    import lmd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int TBL_WORDS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    input  logic              req_super,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_ce,
    output logic [$clog2(TBL_WORDS)-1:0] sram_addr,
    output logic              rom_ce,
    output logic              icache_cancel,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W      = $clog2(TBL_WORDS);
    localparam int LANE_W     = $clog2(DATA_W / 8);
    localparam int REGION_LSB = IDX_W + LANE_W;
    localparam int TAG_W      = ADDR_W - REGION_LSB;
    localparam int NUM_MEM    = 2;

    logic [NUM_MEM-1:0] match;
    logic [7:0]         unused_cfg_bits;
    logic               any_ce;
    logic [IDX_W-1:0]   word_idx;
    logic [DATA_W-1:0]  rom_q;
    logic [DATA_W-1:0]  resp_word;

    phase_e    state, state_nx;
    src_e      src_q;
    logic [1:0] lane_q;
    acc_size_e size_q;

    assign unused_cfg_bits = cfg_wdata[13:6];
    assign word_idx        = req_addr[REGION_LSB-1:LANE_W];

    // one region register and comparator per memory: index 0 SRAM, 1 table
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_region
        lmd_region_match #(.TAG_W(TAG_W)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_sel == 1'(g))),
            .wr_base  (cfg_wdata[31:32-TAG_W]),
            .wr_ctl   (region_ctl_t'(cfg_wdata[5:0])),
            .acc_tag  (req_addr[ADDR_W-1:REGION_LSB]),
            .acc_fetch(req_fetch),
            .acc_super(req_super),
            .match    (match[g])
        );
    end

    // SRAM has priority over the table memory
    assign sram_ce       = req_valid && match[0];
    assign rom_ce        = req_valid && match[1] && !match[0];
    assign any_ce        = sram_ce || rom_ce;
    assign icache_cancel = req_fetch && any_ce;
    assign sram_addr     = word_idx;

    lmd_table_rom #(.IDX_W(IDX_W)) u_rom (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (rom_ce),
        .idx  (word_idx),
        .q    (rom_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: T_WAIT / T_ACCEPT from idle, T_CHAIN / T_DRAIN from data
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = any_ce ? ST_DATA : ST_IDLE;
            ST_DATA: state_nx = any_ce ? ST_DATA : ST_IDLE;
        endcase
    end

    // request attributes captured for the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_SRAM;
            lane_q <= '0;
            size_q <= SZ_WORD;
        end else if (any_ce) begin
            src_q  <= rom_ce ? SRC_TABLE : SRC_SRAM;
            lane_q <= req_addr[1:0];
            size_q <= acc_size_e'(req_size);
        end
    end

    // outputs per state
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                rd_valid  = 1'b0;
                resp_word = '0;
            end
            ST_DATA: begin
                rd_valid  = 1'b1;
                resp_word = (src_q == SRC_TABLE) ? rom_q : sram_rdata;
            end
        endcase
    end

    lmd_lane_align u_align (
        .word(resp_word),
        .lane(lane_q),
        .size(size_q),
        .data(rd_data)
    );

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_fetch,
    input logic [11:0] req_word,
    input logic [1:0]  req_size,
    input logic        sram_ce,
    input logic        rom_ce,
    input logic        icache_cancel,
    input logic        rd_valid,
    input logic [31:0] rd_data
);

    assert_one_memory_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_ce && rom_ce));

    assert_enable_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce || rom_ce) |-> req_valid);

    assert_cancel_only_on_fetch_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        icache_cancel |-> (req_fetch && (sram_ce || rom_ce)));

    assert_fetch_hit_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fetch && (sram_ce || rom_ce)) |-> icache_cancel);

    assert_response_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce || rom_ce) |=> rd_valid);

    assert_no_spurious_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_ce || rom_ce) |=> !rd_valid);

    assert_table_content_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_ce && req_size[1]) |=>
        (rd_data == {4'hA, $past(req_word), 4'h5, $past(req_word)}));

endmodule

bind lmd_local_mem_decoder lmd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_fetch    (req_fetch),
    .req_word     (req_addr[13:2]),
    .req_size     (req_size),
    .sram_ce      (sram_ce),
    .rom_ce       (rom_ce),
    .icache_cancel(icache_cancel),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
);

// File: tb/lmd_local_mem_decoder_tb.sv
module lmd_local_mem_decoder_tb;

    localparam logic [31:0] SRAM_WORD = 32'h1122_3344;
    localparam int NV = 8;
    // {fetch, super, size, addr, exp_sram_ce, exp_rom_ce, exp_cancel}
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'd2, 32'h2000_0010, 1'b1, 1'b0, 1'b1},
        {1'b0, 1'b0, 2'd0, 32'h2000_0013, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 2'd1, 32'h4000_4006, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 2'd2, 32'h4000_7FFC, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 2'd0, 32'h4000_4004, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 2'd1, 32'h2000_3FF0, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 2'd2, 32'h4000_8000, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 2'd2, 32'h2000_4000, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_fetch = 1'b0;
    logic        req_super = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] sram_rdata = SRAM_WORD;
    logic        sram_ce, rom_ce, icache_cancel, rd_valid;
    logic [11:0] sram_addr;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lmd_local_mem_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_fetch(req_fetch), .req_super(req_super), .req_size(req_size),
        .sram_rdata(sram_rdata), .sram_ce(sram_ce), .sram_addr(sram_addr),
        .rom_ce(rom_ce), .icache_cancel(icache_cancel), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    function automatic logic [31:0] exp_table(input logic [11:0] i);
        return {4'hA, i, 4'h5, i};
    endfunction

    function automatic logic [31:0] exp_align(input logic [31:0] w, input logic [1:0] a, input logic [1:0] sz);
        if (sz == 2'd0) return (w >> (8 * (3 - a))) & 32'hFF;
        if (sz == 2'd1) return (w >> (a[1] ? 0 : 16)) & 32'hFFFF;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_region(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic f, input logic s, input logic [1:0] sz, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_fetch = f; req_super = s; req_size = sz; req_addr = a;
        #1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1 and R3: reset state, region base 0 but invalid
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0000; req_fetch = 1'b1;
        #1;
        check("R1 rd_valid in reset", 32'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 sram_ce after reset", 32'(sram_ce), 0);
        check("R3 rom_ce invalid region", 32'(rom_ce), 0);
        check("R1 cancel after reset", 32'(icache_cancel), 0);
        check("R1 rd_valid after reset", 32'(rd_valid), 0);
        idle_cycle();

        write_region(1'b0, 32'h2000_0021);
        write_region(1'b1, 32'h4000_4021);

        // vector table: R2 R6 R7 R8 R9 R10 R12
        for (int i = 0; i < NV; i++) begin
            logic f, s, es, er, ec;
            logic [1:0] sz;
            logic [31:0] a, w;
            {f, s, sz, a, es, er, ec} = VEC[i];
            drive(f, s, sz, a);
            check("R2 sram_ce", 32'(sram_ce), 32'(es));
            check("R2 rom_ce", 32'(rom_ce), 32'(er));
            check("R7 icache_cancel", 32'(icache_cancel), 32'(ec));
            if (es) check("R12 sram_addr", 32'(sram_addr), 32'(a[13:2]));
            idle_cycle();
            check("R8 rd_valid", 32'(rd_valid), 32'(es | er));
            if (es | er) begin
                w = es ? SRAM_WORD : exp_table(a[13:2]);
                check("R10 rd_data", rd_data, exp_align(w, a[1:0], sz));
            end
        end

        // R4: SRAM data only (0x35), table fetch only (0x2B)
        write_region(1'b0, 32'h2000_0035);
        write_region(1'b1, 32'h4000_402B);
        drive(1'b1, 1'b1, 2'd2, 32'h2000_0000);
        check("R4 masked fetch sram_ce", 32'(sram_ce), 0);
        check("R4 masked fetch cancel", 32'(icache_cancel), 0);
        idle_cycle();
        check("R4 masked no response", 32'(rd_valid), 0);
        drive(1'b1, 1'b0, 2'd2, 32'h2000_0000);
        check("R4 masked user fetch", 32'(sram_ce), 0);
        idle_cycle();
        drive(1'b0, 1'b0, 2'd2, 32'h2000_0000);
        check("R4 data allowed", 32'(sram_ce), 1);
        idle_cycle();
        drive(1'b0, 1'b1, 2'd2, 32'h4000_4000);
        check("R4 masked table data", 32'(rom_ce), 0);
        idle_cycle();
        drive(1'b1, 1'b0, 2'd2, 32'h4000_4000);
        check("R4 table fetch allowed", 32'(rom_ce), 1);
        check("R4 table fetch cancel", 32'(icache_cancel), 1);
        idle_cycle();

        // R5: mask bits set but gate clear (0x1F)
        write_region(1'b0, 32'h2000_001F);
        drive(1'b1, 1'b1, 2'd2, 32'h2000_0000);
        check("R5 fetch ignores masks", 32'(sram_ce), 1);
        idle_cycle();
        drive(1'b0, 1'b0, 2'd0, 32'h2000_0000);
        check("R5 data ignores masks", 32'(sram_ce), 1);
        idle_cycle();

        // R6: both regions on the same base
        write_region(1'b0, 32'h6000_0021);
        write_region(1'b1, 32'h6000_0021);
        drive(1'b0, 1'b1, 2'd2, 32'h6000_0100);
        check("R6 sram wins", 32'(sram_ce), 1);
        check("R6 table suppressed", 32'(rom_ce), 0);
        idle_cycle();
        check("R6 sram data returned", rd_data, SRAM_WORD);

        // R3: SRAM invalid, table now answers; R9 content
        write_region(1'b0, 32'h6000_0020);
        drive(1'b0, 1'b1, 2'd2, 32'h6000_048C);
        check("R3 invalid sram", 32'(sram_ce), 0);
        check("R3 table takes over", 32'(rom_ce), 1);
        idle_cycle();
        check("R9 table word 0x123", rd_data, 32'hA123_5123);

        // R11: write and access in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h7000_4021;
        req_valid = 1'b1; req_fetch = 1'b0; req_super = 1'b0; req_size = 2'd2;
        req_addr = 32'h7000_4000;
        #1;
        check("R11 old config this cycle", 32'(sram_ce), 0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R11 new config next cycle", 32'(sram_ce), 1);
        idle_cycle();
        idle_cycle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule